// File: doc/BRIEF.md
# Rotate, Shift and Bit-Operation Unit

This combinational unit serves the execute stage of a small 8-bit processor. It takes one operand byte and does one of four jobs on it. It can rotate or shift the byte. It can swap 4-bit digits between that byte and a second byte. It can test one bit, or force one bit to 1 or 0. A group selector picks the job and a 3-bit operation field picks the variant. A separate bit index names the bit for the single-bit forms. The unit also takes the current flag byte and returns the new flag byte. It drives a write-enable that tells the surrounding datapath whether the result should be stored.

Three kinds of rotate and shift are provided. The full-flag form is used for register and memory operands. The fast form is for the accumulator only and updates Carry alone. The digit rotate works on two bytes: the operand, which is the memory byte, and the accumulator. It returns both bytes. Operand addressing and prefix decoding are done elsewhere. A synthesis parameter chooses what happens to flag bits 5 and 3 after a rotate or digit rotate. They either keep their incoming value or copy the matching result bits.

Top module: `rot_bit_unit`

## Requirements
- R1: In group 0 (full-flag shift), the operation field selects the result as follows. 000 rotates left circular. 001 rotates right circular. 010 rotates left through carry. 011 rotates right through carry. 100 shifts left and fills bit 0 with zero. 101 shifts right and keeps bit 7. 111 shifts right and fills bit 7 with zero. The write-enable is 1.
- R2: The bit that leaves the byte always becomes the new Carry (flag bit 0). A circular rotate also puts that bit into the vacated end. A through-carry rotate puts the old Carry into the vacated end.
- R3: A group-0 operation sets the flags as follows. S (bit 7) is the result's top bit. Z (bit 6) is 1 when the result is zero. H (bit 4) and N (bit 1) are cleared. P/V (bit 2) is 1 for even parity of the result. With the default parameters, bits 5 and 3 keep their incoming value.
- R4: In group 1 (fast accumulator rotate), codes 000 to 011 produce the same result byte and Carry as in group 0. They clear H and N and leave S, Z, P/V, bit 5 and bit 3 unchanged.
- R5: Some selections are reserved: group 0 with code 110, group 1 with codes 100 to 111, and groups 6 and 7. A reserved selection returns the operand and accumulator unchanged and the flags unchanged, and the write-enable is 0.
- R6: In group 2 with operation bit 0 = 0 (digit rotate left), the new memory byte is {old memory low nibble, old accumulator low nibble}. The new accumulator is {old accumulator high nibble, old memory high nibble}.
- R7: In group 2 with operation bit 0 = 1 (digit rotate right), the new memory byte is {old accumulator low nibble, old memory high nibble}. The new accumulator is {old accumulator high nibble, old memory low nibble}.
- R8: A digit rotate sets S, Z and even parity (P/V) from the new accumulator. It clears H and N, leaves Carry unchanged and asserts the write-enable.
- R9: Group 3 (bit test) sets Z to the inverse of operand bit `bit_i` and sets P/V equal to the new Z. It sets H to 1, clears N, and leaves S, Carry, bit 5 and bit 3 unchanged. The result is the unchanged operand and the write-enable is 0.
- R10: Group 4 sets operand bit `bit_i` and group 5 clears it. All other bits are kept, the flags are unchanged and the write-enable is 1.
- R11: Outside group 2 the accumulator output equals the accumulator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_i | input | DATA_W (8) | Operand byte; the memory byte for digit rotates |
| acc_i | input | DATA_W (8) | Accumulator byte used by digit rotates |
| flags_i | input | 8 | Current flag byte (S7 Z6 5 H4 3 PV2 N1 C0) |
| grp_i | input | 3 | Group: 0 full shift, 1 fast accumulator, 2 digit, 3 test, 4 set, 5 clear, 6/7 reserved |
| op_i | input | 3 | Operation code within the group |
| bit_i | input | BIDX_W (3) | Bit index for groups 3 to 5 |
| res_o | output | DATA_W (8) | Result byte (operand or memory byte) |
| acc_o | output | DATA_W (8) | Accumulator result |
| wr_o | output | 1 | Result write-enable |
| flags_o | output | 8 | New flag byte |

## Verification
The bench builds the unit with its defaults: an 8-bit data width and flag bits 5 and 3 preserved. At this width all 256 operand values can be swept through every shift code and every bit index. Every carry-in and every edge bit is therefore covered. Because bits 5 and 3 are preserved, the table rows can use flag bytes with those bits set and check that rotates leave them untouched. The table also targets the zero results and the parity boundaries. It covers the edge where the fast accumulator form and the full-flag form give different S, Z and P/V.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
   typedef enum logic [2:0] {
      GRP_SHF  = 3'd0,
      GRP_ACC  = 3'd1,
      GRP_DIG  = 3'd2,
      GRP_TST  = 3'd3,
      GRP_SET  = 3'd4,
      GRP_CLR  = 3'd5,
      GRP_RSV6 = 3'd6,
      GRP_RSV7 = 3'd7
   } grp_e;

   typedef enum logic [2:0] {
      SH_RLC = 3'd0,
      SH_RRC = 3'd1,
      SH_RL  = 3'd2,
      SH_RR  = 3'd3,
      SH_SLA = 3'd4,
      SH_SRA = 3'd5,
      SH_RSV = 3'd6,
      SH_SRL = 3'd7
   } shop_e;

   typedef enum logic [1:0] {
      BM_TEST = 2'd0,
      BM_SET  = 2'd1,
      BM_CLR  = 2'd2
   } bmode_e;

   localparam int FLW   = 8;
   localparam int FL_S  = 7;
   localparam int FL_Z  = 6;
   localparam int FL_Y  = 5;
   localparam int FL_H  = 4;
   localparam int FL_X  = 3;
   localparam int FL_PV = 2;
   localparam int FL_N  = 1;
   localparam int FL_C  = 0;
endpackage

// File: rtl/rbu_shift_core.sv
module rbu_shift_core
   import rbu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opd_i,
   input  logic              cin_i,
   input  logic [2:0]        code_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o,
   output logic              valid_o
);
   localparam int MSB = DATA_W - 1;

   shop_e code;
   assign code = shop_e'(code_i);

   always_comb begin
      res_o   = opd_i;
      cout_o  = cin_i;
      valid_o = 1'b1;
      unique case (code)
         SH_RLC: begin res_o = {opd_i[MSB-1:0], opd_i[MSB]}; cout_o = opd_i[MSB]; end
         SH_RRC: begin res_o = {opd_i[0], opd_i[MSB:1]};     cout_o = opd_i[0];   end
         SH_RL:  begin res_o = {opd_i[MSB-1:0], cin_i};      cout_o = opd_i[MSB]; end
         SH_RR:  begin res_o = {cin_i, opd_i[MSB:1]};        cout_o = opd_i[0];   end
         SH_SLA: begin res_o = {opd_i[MSB-1:0], 1'b0};       cout_o = opd_i[MSB]; end
         SH_SRA: begin res_o = {opd_i[MSB], opd_i[MSB:1]};   cout_o = opd_i[0];   end
         SH_SRL: begin res_o = {1'b0, opd_i[MSB:1]};         cout_o = opd_i[0];   end
         SH_RSV: begin valid_o = 1'b0; end
         default: begin valid_o = 1'b0; end
      endcase
   end

   // leaving bit reaches carry; shifts obey their fill rules
   always_comb begin
      if (!$isunknown({opd_i, cin_i, code_i})) begin
         if (code_i != 3'd6) begin
            assert_carry_out_R2: assert (cout_o == (code_i[0] ? opd_i[0] : opd_i[MSB]));
         end
         if (code_i == 3'd5) begin
            assert_sra_keeps_sign_R1: assert (res_o[MSB] == opd_i[MSB]);
         end
         if (code_i == 3'd7) begin
            assert_srl_zero_fill_R1: assert (res_o[MSB] == 1'b0);
         end
         if (code_i == 3'd6) begin
            assert_reserved_code_R5: assert (!valid_o && res_o == opd_i);
         end
      end
   end
endmodule

// File: rtl/rbu_digit_rot.sv
module rbu_digit_rot #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] mem_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              right_i,
   output logic [DATA_W-1:0] mem_o,
   output logic [DATA_W-1:0] acc_o
);
   localparam int HW = DATA_W / 2;

   logic [HW-1:0] m_hi, m_lo, a_hi, a_lo;
   assign m_hi = mem_i[DATA_W-1:HW];
   assign m_lo = mem_i[HW-1:0];
   assign a_hi = acc_i[DATA_W-1:HW];
   assign a_lo = acc_i[HW-1:0];

   always_comb begin
      if (right_i) begin
         mem_o = {a_lo, m_hi};
         acc_o = {a_hi, m_lo};
      end else begin
         mem_o = {m_lo, a_lo};
         acc_o = {a_hi, m_hi};
      end
   end

   always_comb begin
      if (!$isunknown({mem_i, acc_i, right_i})) begin
         assert_acc_high_kept_R6: assert (acc_o[DATA_W-1:HW] == acc_i[DATA_W-1:HW]);
         if (!right_i) begin
            assert_left_moves_low_up_R6: assert (mem_o[DATA_W-1:HW] == mem_i[HW-1:0]);
         end else begin
            assert_right_moves_high_down_R7: assert (mem_o[HW-1:0] == mem_i[DATA_W-1:HW]);
         end
      end
   end
endmodule

// File: rtl/rbu_bit_op.sv
module rbu_bit_op
   import rbu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BIDX_W = 3
) (
   input  logic [DATA_W-1:0] opd_i,
   input  logic [BIDX_W-1:0] idx_i,
   input  logic [1:0]        mode_i,
   output logic [DATA_W-1:0] res_o,
   output logic              zero_o
);
   logic [DATA_W-1:0] mask;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign mask[gi] = (idx_i == BIDX_W'(gi));
   end

   always_comb begin
      zero_o = ~|(opd_i & mask);
      unique case (bmode_e'(mode_i))
         BM_SET:  res_o = opd_i | mask;
         BM_CLR:  res_o = opd_i & ~mask;
         default: res_o = opd_i;
      endcase
   end

   always_comb begin
      if (!$isunknown({opd_i, idx_i, mode_i})) begin
         assert_one_bit_touched_R10: assert ($countones(res_o ^ opd_i) <= 1);
         assert_zero_is_inverse_R9: assert (zero_o == !opd_i[idx_i]);
      end
   end
endmodule

// File: rtl/rot_bit_unit.sv
module rot_bit_unit
   import rbu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit COPY_XY = 1'b0,
   localparam int BIDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opd_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [FLW-1:0]    flags_i,
   input  logic [2:0]        grp_i,
   input  logic [2:0]        op_i,
   input  logic [BIDX_W-1:0] bit_i,
   output logic [DATA_W-1:0] res_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              wr_o,
   output logic [FLW-1:0]    flags_o
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W % 2 != 0 || DATA_W < 4) begin : g_bad_width
      $error("rot_bit_unit: DATA_W must be even and at least 4");
   end
   if (COPY_XY && DATA_W < 6) begin : g_bad_xy
      $error("rot_bit_unit: COPY_XY needs DATA_W of at least 6");
   end

   grp_e grp;
   assign grp = grp_e'(grp_i);

   logic [DATA_W-1:0] sh_res, dg_mem, dg_acc, bo_res;
   logic              sh_cout, sh_valid, bo_zero;
   logic [1:0]        bo_mode;
   logic [1:0]        xy_sh, xy_dg;

   rbu_shift_core #(.DATA_W(DATA_W)) u_shift (
      .opd_i   (opd_i),
      .cin_i   (flags_i[FL_C]),
      .code_i  (op_i),
      .res_o   (sh_res),
      .cout_o  (sh_cout),
      .valid_o (sh_valid)
   );

   rbu_digit_rot #(.DATA_W(DATA_W)) u_digit (
      .mem_i   (opd_i),
      .acc_i   (acc_i),
      .right_i (op_i[0]),
      .mem_o   (dg_mem),
      .acc_o   (dg_acc)
   );

   assign bo_mode = (grp == GRP_SET) ? BM_SET : (grp == GRP_CLR) ? BM_CLR : BM_TEST;

   rbu_bit_op #(.DATA_W(DATA_W), .BIDX_W(BIDX_W)) u_bitop (
      .opd_i  (opd_i),
      .idx_i  (bit_i),
      .mode_i (bo_mode),
      .res_o  (bo_res),
      .zero_o (bo_zero)
   );

   if (COPY_XY) begin : g_xy_copy
      assign xy_sh = {sh_res[FL_Y], sh_res[FL_X]};
      assign xy_dg = {dg_acc[FL_Y], dg_acc[FL_X]};
   end else begin : g_xy_keep
      assign xy_sh = {flags_i[FL_Y], flags_i[FL_X]};
      assign xy_dg = {flags_i[FL_Y], flags_i[FL_X]};
   end

   always_comb begin
      res_o   = opd_i;
      acc_o   = acc_i;
      wr_o    = 1'b0;
      flags_o = flags_i;
      unique case (grp)
         GRP_SHF: if (sh_valid) begin
            res_o           = sh_res;
            wr_o            = 1'b1;
            flags_o[FL_S]   = sh_res[MSB];
            flags_o[FL_Z]   = ~|sh_res;
            flags_o[FL_H]   = 1'b0;
            flags_o[FL_PV]  = ~^sh_res;
            flags_o[FL_N]   = 1'b0;
            flags_o[FL_C]   = sh_cout;
            flags_o[FL_Y]   = xy_sh[1];
            flags_o[FL_X]   = xy_sh[0];
         end
         GRP_ACC: if (!op_i[2]) begin
            res_o           = sh_res;
            wr_o            = 1'b1;
            flags_o[FL_H]   = 1'b0;
            flags_o[FL_N]   = 1'b0;
            flags_o[FL_C]   = sh_cout;
            flags_o[FL_Y]   = xy_sh[1];
            flags_o[FL_X]   = xy_sh[0];
         end
         GRP_DIG: begin
            res_o           = dg_mem;
            acc_o           = dg_acc;
            wr_o            = 1'b1;
            flags_o[FL_S]   = dg_acc[MSB];
            flags_o[FL_Z]   = ~|dg_acc;
            flags_o[FL_H]   = 1'b0;
            flags_o[FL_PV]  = ~^dg_acc;
            flags_o[FL_N]   = 1'b0;
            flags_o[FL_Y]   = xy_dg[1];
            flags_o[FL_X]   = xy_dg[0];
         end
         GRP_TST: begin
            flags_o[FL_Z]   = bo_zero;
            flags_o[FL_PV]  = bo_zero;
            flags_o[FL_H]   = 1'b1;
            flags_o[FL_N]   = 1'b0;
         end
         GRP_SET, GRP_CLR: begin
            res_o = bo_res;
            wr_o  = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      if (!$isunknown({opd_i, acc_i, flags_i, grp_i, op_i, bit_i})) begin
         if ((grp_i == 3'd0 && op_i == 3'd6) || (grp_i == 3'd1 && op_i[2]) || grp_i[2:1] == 2'b11) begin
            assert_reserved_inert_R5: assert (!wr_o && flags_o == flags_i && res_o == opd_i);
         end
         if (grp_i == 3'd1 && !op_i[2]) begin
            assert_fast_keeps_szp_R4: assert (flags_o[FL_S] == flags_i[FL_S] &&
               flags_o[FL_Z] == flags_i[FL_Z] && flags_o[FL_PV] == flags_i[FL_PV]);
         end
         if (grp_i != 3'd2) begin
            assert_acc_passthrough_R11: assert (acc_o == acc_i);
         end
         if (grp_i == 3'd2 || grp_i == 3'd3) begin
            assert_carry_kept_R8: assert (flags_o[FL_C] == flags_i[FL_C]);
         end
         if (grp_i == 3'd3) begin
            assert_test_pv_follows_z_R9: assert (flags_o[FL_PV] == flags_o[FL_Z] && !wr_o);
         end
         if (grp_i == 3'd4 || grp_i == 3'd5) begin
            assert_setclr_flags_kept_R10: assert (flags_o == flags_i && wr_o);
         end
      end
   end
endmodule

// File: tb/rot_bit_unit_bench.sv
`timescale 1ns/1ps
module rot_bit_unit_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] opd, acc, flg;
   logic [2:0] grp, op, bidx;
   logic [7:0] res, acc_q, flg_q;
   logic       wr;
   int         checks = 0;
   int         errors = 0;

   always #5 clk = ~clk;

   rot_bit_unit u_rot_bit_unit (
      .opd_i(opd), .acc_i(acc), .flags_i(flg), .grp_i(grp), .op_i(op), .bit_i(bidx),
      .res_o(res), .acc_o(acc_q), .wr_o(wr), .flags_o(flg_q)
   );

   // {req4, grp3, op3, bit3, opd8, acc8, flg8, eres8, eacc8, ewr1, eflg8}
   localparam int NV = 20;
   localparam logic [61:0] VEC [NV] = '{
      {4'd1, 3'd0,3'd0,3'd0, 8'h85,8'h5C,8'h00, 8'h0B,8'h5C,1'b1,8'h01}, // R1 rotate left circular
      {4'd2, 3'd0,3'd1,3'd0, 8'h01,8'h5C,8'h00, 8'h80,8'h5C,1'b1,8'h81}, // R2 right circular
      {4'd3, 3'd0,3'd2,3'd0, 8'h80,8'h5C,8'h12, 8'h00,8'h5C,1'b1,8'h45}, // R3 zero result, even parity
      {4'd2, 3'd0,3'd3,3'd0, 8'h01,8'h5C,8'h01, 8'h80,8'h5C,1'b1,8'h81}, // R2 carry shifted in
      {4'd1, 3'd0,3'd4,3'd0, 8'hC1,8'h5C,8'h01, 8'h82,8'h5C,1'b1,8'h85}, // R1 shift left
      {4'd1, 3'd0,3'd5,3'd0, 8'h81,8'h5C,8'h00, 8'hC0,8'h5C,1'b1,8'h85}, // R1 arithmetic right
      {4'd3, 3'd0,3'd7,3'd0, 8'h81,8'h5C,8'h2A, 8'h40,8'h5C,1'b1,8'h29}, // R3 bits 5/3 kept
      {4'd5, 3'd0,3'd6,3'd0, 8'h5A,8'h5C,8'hD7, 8'h5A,8'h5C,1'b0,8'hD7}, // R5 reserved code
      {4'd4, 3'd1,3'd0,3'd0, 8'h80,8'h5C,8'hFE, 8'h01,8'h5C,1'b1,8'hED}, // R4 fast rotate
      {4'd4, 3'd1,3'd3,3'd0, 8'h02,8'h5C,8'h01, 8'h81,8'h5C,1'b1,8'h00}, // R4 S not updated
      {4'd5, 3'd1,3'd4,3'd0, 8'h33,8'h5C,8'h12, 8'h33,8'h5C,1'b0,8'h12}, // R5 fast reserved
      {4'd6, 3'd2,3'd0,3'd0, 8'h34,8'h12,8'h01, 8'h42,8'h13,1'b1,8'h01}, // R6 digit left
      {4'd7, 3'd2,3'd1,3'd0, 8'h34,8'h12,8'h00, 8'h23,8'h14,1'b1,8'h04}, // R7 digit right
      {4'd8, 3'd2,3'd0,3'd0, 8'h0F,8'h80,8'h00, 8'hF0,8'h80,1'b1,8'h80}, // R8 sign from acc
      {4'd8, 3'd2,3'd1,3'd0, 8'h00,8'h05,8'h00, 8'h50,8'h00,1'b1,8'h44}, // R8 zero acc
      {4'd9, 3'd3,3'd0,3'd3, 8'h08,8'h5C,8'h01, 8'h08,8'h5C,1'b0,8'h11}, // R9 tested bit set
      {4'd9, 3'd3,3'd0,3'd7, 8'h7F,8'h5C,8'h83, 8'h7F,8'h5C,1'b0,8'hD5}, // R9 tested bit clear
      {4'd10,3'd4,3'd0,3'd0, 8'h00,8'h5C,8'hA5, 8'h01,8'h5C,1'b1,8'hA5}, // R10 set
      {4'd10,3'd5,3'd0,3'd7, 8'hFF,8'h5C,8'h42, 8'h7F,8'h5C,1'b1,8'h42}, // R10 clear
      {4'd11,3'd6,3'd0,3'd0, 8'h99,8'h5C,8'h3C, 8'h99,8'h5C,1'b0,8'h3C}  // R11 / R5 group 6
   };

   task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (res,acc,wr,flags)", req, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] g, input logic [2:0] o, input logic [2:0] b,
                        input logic [7:0] d, input logic [7:0] a, input logic [7:0] f);
      @(posedge clk);
      #1;
      grp = g; op = o; bidx = b; opd = d; acc = a; flg = f;
      @(negedge clk);
   endtask

   function automatic logic [8:0] model_shift(input logic [2:0] c, input logic [7:0] v, input logic ci);
      case (c)
         3'd0: return {v[7], v[6:0], v[7]};
         3'd1: return {v[0], v[0], v[7:1]};
         3'd2: return {v[7], v[6:0], ci};
         3'd3: return {v[0], ci, v[7:1]};
         3'd4: return {v[7], v[6:0], 1'b0};
         3'd5: return {v[0], v[7], v[7:1]};
         default: return {v[0], 1'b0, v[7:1]};
      endcase
   endfunction

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      grp = 3'd6; op = 3'd0; bidx = 3'd0; opd = 8'h00; acc = 8'h00; flg = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R5 reset idle", {res, acc_q, wr, flg_q}, {8'h00, 8'h00, 1'b0, 8'h00});
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [61:0] v;
         v = VEC[i];
         apply(v[57:55], v[54:52], v[51:49], v[48:41], v[40:33], v[32:25]);
         check($sformatf("R%0d vector %0d", v[61:58], i), {res, acc_q, wr, flg_q}, v[24:0]);
      end

      // R1 R2 R3: sweep every operand through every full-flag code
      for (int c = 0; c < 8; c++) begin
         if (c == 6) continue;
         for (int d = 0; d < 256; d++) begin
            logic [8:0] m;
            logic [7:0] f, ef;
            f = d[7:0] ^ 8'h5A;
            m = model_shift(c[2:0], d[7:0], f[0]);
            ef = {m[7], m[7:0] == 8'h00, f[5], 1'b0, f[3], ~^m[7:0], 1'b0, m[8]};
            apply(3'd0, c[2:0], 3'd0, d[7:0], 8'hA5, f);
            check("R1 R2 R3 sweep", {res, acc_q, wr, flg_q}, {m[7:0], 8'hA5, 1'b1, ef});
         end
      end

      // R9 R10: every bit index over every operand
      for (int b = 0; b < 8; b++) begin
         for (int d = 0; d < 256; d++) begin
            logic [7:0] ef;
            logic       z;
            z = ~d[b];
            ef = d[7:0];
            ef[6] = z; ef[2] = z; ef[4] = 1'b1; ef[1] = 1'b0;
            apply(3'd3, 3'd0, b[2:0], d[7:0], 8'h3C, d[7:0]);
            check("R9 test sweep", {res, acc_q, wr, flg_q}, {d[7:0], 8'h3C, 1'b0, ef});
            apply(3'd4, 3'd0, b[2:0], d[7:0], 8'h3C, d[7:0]);
            check("R10 set sweep", {res, acc_q, wr, flg_q},
                  {d[7:0] | (8'h01 << b), 8'h3C, 1'b1, d[7:0]});
            apply(3'd5, 3'd0, b[2:0], d[7:0], 8'h3C, d[7:0]);
            check("R10 clear sweep", {res, acc_q, wr, flg_q},
                  {d[7:0] & ~(8'h01 << b), 8'h3C, 1'b1, d[7:0]});
         end
      end

      // R5: remaining reserved fast codes and group 7
      for (int o = 4; o < 8; o++) begin
         apply(3'd1, o[2:0], 3'd2, 8'hE7, 8'h18, 8'h6B);
         check("R5 fast reserved", {res, acc_q, wr, flg_q}, {8'hE7, 8'h18, 1'b0, 8'h6B});
      end
      apply(3'd7, 3'd3, 3'd5, 8'hC3, 8'h77, 8'hFF);
      check("R5 group 7", {res, acc_q, wr, flg_q}, {8'hC3, 8'h77, 1'b0, 8'hFF});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule